// File: doc/BRIEF.md
# Four-Function Arithmetic and Logic Unit with Status Flags

This block is a purely combinational integer unit of parameterised width (32 bits unless set otherwise). From two operands and a two-bit operation code it returns a sum, a difference, a bitwise AND or a bitwise OR. It also returns four status flags that describe that result: sign, all-zero, carry out and signed overflow. A processor datapath places it between the register read ports and the write-back path, and a flag register further down the datapath captures the flags.

Addition and subtraction share one carry-propagate adder. Bit 0 of the operation code inverts the second operand and also feeds the adder's carry input, which turns A + B into A + ~B + 1. A result multiplexer then chooses between the adder output and the logic unit. A parameter sets the adder structure: a parallel-prefix carry tree or a plain ripple chain. Both structures compute the same function.

Top module: `alu_core`

## Requirements
- R1: With op_i = 2'b00, res_o equals (a_i + b_i) modulo 2^WIDTH.
- R2: With op_i = 2'b01, res_o equals (a_i - b_i) modulo 2^WIDTH, formed as a_i + ~b_i + 1.
- R3: With op_i = 2'b10, res_o equals the bitwise AND of a_i and b_i.
- R4: With op_i = 2'b11, res_o equals the bitwise OR of a_i and b_i.
- R5: neg_o equals bit WIDTH-1 of res_o for every operation.
- R6: zero_o is 1 exactly when all bits of res_o are 0, for every operation.
- R7: For op_i = 2'b00 or 2'b01, carry_o is the adder carry out. For subtraction this is 1 when a_i >= b_i unsigned, so 0 - 0 gives carry_o = 1.
- R8: For op_i = 2'b10 or 2'b11, carry_o is 0.
- R9: For op_i = 2'b00, ovf_o is 1 exactly when a_i and b_i have the same sign and res_o has the other sign.
- R10: For op_i = 2'b01, ovf_o is 1 exactly when a_i and b_i differ in sign and res_o differs in sign from a_i.
- R11: For op_i = 2'b10 or 2'b11, ovf_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 AND, 11 OR |
| res_o | output | WIDTH | Selected result |
| neg_o | output | 1 | Sign of the result |
| zero_o | output | 1 | Result is all zeros |
| carry_o | output | 1 | Adder carry out, arithmetic operations only |
| ovf_o | output | 1 | Signed overflow, arithmetic operations only |

## Verification
Carry and signed overflow are both taken from the single shared adder, so they can be raised by the same operation. Adding two large negative numbers, for example 0x80000000 + 0x80000000, sets both flags at once and also sets zero. Subtracting a negative number from the largest positive value overflows with the carry clear. Each case is judged against a reference that works on widened arithmetic, and the bench compares all five outputs for every vector.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [1:0] {
      OP_ADD = 2'b00,
      OP_SUB = 2'b01,
      OP_AND = 2'b10,
      OP_OR  = 2'b11
   } alu_op_e;

   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_PREFIX = 1;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH = 32,
   parameter int KIND  = alu_pkg::ADDER_PREFIX
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);
   localparam int COLS   = WIDTH + 1;
   localparam int LEVELS = $clog2(COLS);

   logic [WIDTH-1:0] half;
   logic [WIDTH:0]   cin_vec;

   assign half   = x_i ^ y_i;
   assign sum_o  = half ^ cin_vec[WIDTH-1:0];
   assign cout_o = cin_vec[WIDTH];

   if (KIND == alu_pkg::ADDER_PREFIX) begin : g_prefix
      logic [LEVELS:0][WIDTH:0] gg;
      logic [LEVELS:0][WIDTH:0] pp;
      always_comb begin
         gg = '0;
         pp = '0;
         gg[0][0] = cin_i;
         for (int i = 0; i < WIDTH; i++) begin
            gg[0][i+1] = x_i[i] & y_i[i];
            pp[0][i+1] = x_i[i] | y_i[i];
         end
         for (int l = 0; l < LEVELS; l++) begin
            for (int j = 0; j <= WIDTH; j++) begin
               if (j >= (1 << l)) begin
                  gg[l+1][j] = gg[l][j] | (pp[l][j] & gg[l][j-(1<<l)]);
                  pp[l+1][j] = pp[l][j] & pp[l][j-(1<<l)];
               end else begin
                  gg[l+1][j] = gg[l][j];
                  pp[l+1][j] = pp[l][j];
               end
            end
         end
      end
      assign cin_vec = gg[LEVELS];
   end else begin : g_ripple
      always_comb begin
         cin_vec[0] = cin_i;
         for (int i = 0; i < WIDTH; i++) begin
            cin_vec[i+1] = (x_i[i] & y_i[i]) | (half[i] & cin_vec[i]);
         end
      end
   end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic             use_or_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] out_o
);
   assign out_o = use_or_i ? (a_i | b_i) : (a_i & b_i);
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
   parameter int WIDTH = 32
) (
   input  alu_pkg::alu_op_e op_i,
   input  logic             a_msb_i,
   input  logic             b_msb_i,
   input  logic             sum_msb_i,
   input  logic             cout_i,
   input  logic [WIDTH-1:0] res_i,
   output logic             neg_o,
   output logic             zero_o,
   output logic             carry_o,
   output logic             ovf_o
);
   logic arith;
   logic sign_rule;

   assign arith     = ~op_i[1];
   // add wants equal operand signs, subtract wants differing signs
   assign sign_rule = ~(op_i[0] ^ a_msb_i ^ b_msb_i);

   assign neg_o   = res_i[WIDTH-1];
   assign zero_o  = ~|res_i;
   assign carry_o = arith & cout_i;
   assign ovf_o   = arith & (a_msb_i ^ sum_msb_i) & sign_rule;
endmodule

// File: rtl/alu_core.sv
module alu_core #(
   parameter int WIDTH      = 32,
   parameter int ADDER_KIND = alu_pkg::ADDER_PREFIX
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [1:0]       op_i,
   output logic [WIDTH-1:0] res_o,
   output logic             neg_o,
   output logic             zero_o,
   output logic             carry_o,
   output logic             ovf_o
);
   import alu_pkg::*;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_core: WIDTH must be at least 2");
   end
   if (ADDER_KIND != ADDER_RIPPLE && ADDER_KIND != ADDER_PREFIX) begin : g_bad_kind
      $error("alu_core: unknown ADDER_KIND");
   end

   alu_op_e          op;
   logic [WIDTH-1:0] b_eff;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic [WIDTH-1:0] logic_out;

   assign op    = alu_op_e'(op_i);
   assign b_eff = b_i ^ {WIDTH{op_i[0]}};

   alu_adder #(.WIDTH(WIDTH), .KIND(ADDER_KIND)) u_adder (
      .x_i   (a_i),
      .y_i   (b_eff),
      .cin_i (op_i[0]),
      .sum_o (sum),
      .cout_o(cout)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .use_or_i(op_i[0]),
      .a_i     (a_i),
      .b_i     (b_i),
      .out_o   (logic_out)
   );

   assign res_o = op_i[1] ? logic_out : sum;

   alu_flags #(.WIDTH(WIDTH)) u_flags (
      .op_i     (op),
      .a_msb_i  (a_i[WIDTH-1]),
      .b_msb_i  (b_i[WIDTH-1]),
      .sum_msb_i(sum[WIDTH-1]),
      .cout_i   (cout),
      .res_i    (res_o),
      .neg_o    (neg_o),
      .zero_o   (zero_o),
      .carry_o  (carry_o),
      .ovf_o    (ovf_o)
   );
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic [1:0]       op_i,
   input logic [WIDTH-1:0] res_o,
   input logic             neg_o,
   input logic             zero_o,
   input logic             carry_o,
   input logic             ovf_o
);
   always_comb begin
      if (!$isunknown({a_i, b_i, op_i})) begin
         if (op_i == 2'b00)
            p_add_sum_r1: assert (res_o - b_i == a_i);
         if (op_i == 2'b01)
            p_sub_diff_r2: assert (res_o + b_i == a_i);
         if (op_i == 2'b10)
            p_and_subset_r3: assert (((res_o & ~a_i) | (res_o & ~b_i)) == '0);
         if (op_i == 2'b11)
            p_or_cover_r4: assert (((a_i | b_i) & ~res_o) == '0);
         p_sign_r5: assert (neg_o == res_o[WIDTH-1]);
         p_zero_r6: assert (zero_o == (res_o == '0));
         if (op_i == 2'b01 && a_i == b_i)
            p_sub_self_carry_r7: assert (carry_o && zero_o);
         if (op_i[1])
            p_no_carry_r8: assert (!carry_o);
         if (op_i == 2'b00 && a_i[WIDTH-1] != b_i[WIDTH-1])
            p_add_mixed_sign_r9: assert (!ovf_o);
         if (op_i == 2'b01 && a_i[WIDTH-1] == b_i[WIDTH-1])
            p_sub_same_sign_r10: assert (!ovf_o);
         if (op_i[1])
            p_no_overflow_r11: assert (!ovf_o);
      end
   end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_chk (
   .a_i    (a_i),
   .b_i    (b_i),
   .op_i   (op_i),
   .res_o  (res_o),
   .neg_o  (neg_o),
   .zero_o (zero_o),
   .carry_o(carry_o),
   .ovf_o  (ovf_o)
);

// File: tb/alu_core_test.sv
module alu_core_test;
   localparam int W          = 32;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 50000;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a, b;
   logic [1:0]   op;
   logic [W-1:0] res;
   logic         neg, zero, carry, ovf;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   logic [31:0] lfsr = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu_core #(.WIDTH(W)) uut (
      .a_i(a), .b_i(b), .op_i(op),
      .res_o(res), .neg_o(neg), .zero_o(zero), .carry_o(carry), .ovf_o(ovf)
   );

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      logic [31:0] t = s;
      t ^= t << 13;
      t ^= t >> 17;
      t ^= t << 5;
      return t;
   endfunction

   task automatic fail_line(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      bad++;
      $display("FAIL %s a=%h b=%h op=%b actual=%h expected=%h", req, a, b, op, act, exp);
   endtask

   // apply one vector and compare all outputs to a widened-arithmetic reference
   task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic [1:0] vop);
      logic [W:0]   wide;
      logic [W-1:0] e_res;
      logic         e_c, e_v;
      @(posedge clk);
      a = va; b = vb; op = vop;
      @(negedge clk);
      total++;
      e_c = 1'b0; e_v = 1'b0;
      case (vop)
         2'b00: begin
            wide  = {1'b0, va} + {1'b0, vb};
            e_res = wide[W-1:0];
            e_c   = wide[W];
            e_v   = (va[W-1] == vb[W-1]) && (e_res[W-1] != va[W-1]);
         end
         2'b01: begin
            wide  = {1'b0, va} - {1'b0, vb};
            e_res = wide[W-1:0];
            e_c   = (va >= vb);
            e_v   = (va[W-1] != vb[W-1]) && (e_res[W-1] != va[W-1]);
         end
         2'b10: e_res = va & vb;
         default: e_res = va | vb;
      endcase
      if (res !== e_res) begin
         case (vop)
            2'b00: fail_line("R1 sum", res, e_res);
            2'b01: fail_line("R2 difference", res, e_res);
            2'b10: fail_line("R3 and", res, e_res);
            default: fail_line("R4 or", res, e_res);
         endcase
      end
      if (neg !== e_res[W-1]) fail_line("R5 negative", W'(neg), W'(e_res[W-1]));
      if (zero !== (e_res == '0)) fail_line("R6 zero", W'(zero), W'(e_res == '0));
      if (carry !== e_c) fail_line(vop[1] ? "R8 carry" : "R7 carry", W'(carry), W'(e_c));
      if (ovf !== e_v) begin
         case (vop)
            2'b00: fail_line("R9 overflow", W'(ovf), W'(e_v));
            2'b01: fail_line("R10 overflow", W'(ovf), W'(e_v));
            default: fail_line("R11 overflow", W'(ovf), W'(e_v));
         endcase
      end
   endtask

   // initial state: all-zero operands with add selected (R6 zero, R7 no carry)
   task automatic t_reset;
      apply('0, '0, 2'b00);
   endtask

   task automatic t_add;   // R1 R7 R9
      apply(32'd5, 32'd7, 2'b00);
      apply(32'h7FFF_FFFF, 32'd1, 2'b00);
      apply(32'hFFFF_FFFF, 32'd1, 2'b00);
      apply(32'h8000_0000, 32'h8000_0000, 2'b00);
      apply(32'h8000_0000, 32'hFFFF_FFFF, 2'b00);
      apply(32'h7FFF_FFFF, 32'h8000_0000, 2'b00);
   endtask

   task automatic t_sub;   // R2 R7 R10
      apply(32'd0, 32'd0, 2'b01);
      apply(32'h8000_0000, 32'd1, 2'b01);
      apply(32'h1234_5678, 32'h1234_5678, 2'b01);
      apply(32'd3, 32'd9, 2'b01);
      apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b01);
      apply(32'hFFFF_FFFF, 32'h7FFF_FFFF, 2'b01);
   endtask

   task automatic t_logic; // R3 R4 R8 R11 with operands that would carry and overflow
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10);
      apply(32'h8000_0000, 32'h8000_0000, 2'b11);
      apply(32'hF0F0_F0F0, 32'h0F0F_0F0F, 2'b10);
      apply(32'hF0F0_F0F0, 32'h0F0F_0F0F, 2'b11);
      apply(32'd0, 32'd0, 2'b11);
   endtask

   task automatic t_sweep; // all requirements over pseudo-random operands
      for (int n = 0; n < 400; n++) begin
         logic [W-1:0] ra, rb;
         lfsr = next_rand(lfsr); ra = lfsr;
         lfsr = next_rand(lfsr); rb = lfsr;
         apply(ra, rb, 2'(n));
      end
   endtask

   initial begin
      a = '0; b = '0; op = 2'b00;
      repeat (2) @(posedge clk);
      rst = 1'b0;
      t_reset();
      t_add();
      t_sub();
      t_logic();
      t_sweep();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule